// File: doc/BRIEF.md
# Hardware breakpoint and trace unit

This block sits beside a processor pipeline and watches it for debug events. Each fetch address is compared against two instruction-breakpoint registers. Each load or store address is compared against two data-breakpoint registers, and a control register sets how those registers behave. The block also takes a software-breakpoint pulse, an external debug request and exception-taken reports. Every taken branch target is written into a 256-entry trace buffer.

The first event raises a debug-stop request and holds a 3-bit cause code. The code stays fixed until the debugger clears it. While a stop is pending, trace capture is frozen. A debugger reads and writes the registers, and reads trace entries by slot index, through a simple word-wide register port. Register reads are combinational.

Top module: `dbg_event_unit`

## Requirements
- R1: Instruction breakpoint `k` (register 0 or 1) matches when its enable bit (control bit `k`) is set, `fetch_valid_i` is high and `fetch_addr_i` equals the register exactly. A match sets `stop_o` and cause 1 at the next clock edge. A disabled register never matches.
- R2: Data breakpoint `k` (register 2 or 3) has an enable bit (control bit 2+k) and a 2-bit access mode at control bits [5:4] for register 2 and [7:6] for register 3. In the mode field, bit 0 selects loads and bit 1 selects stores, and `mem_store_i` tells the two apart. A match sets cause 2.
- R3: When control bit 8 is set, register 3 stops working as a comparator. Its set bits then mark address bits that the register-2 compare ignores.
- R4: A `swbrk_i` pulse gives cause 3, and `ext_dbg_i` gives cause 4. Each sets `stop_o` at the next edge.
- R5: `exc_taken_i` gives cause 5 only when control bit 10+`exc_vec_i` is set.
- R6: When events arrive in the same cycle, the smallest cause code wins.
- R7: Once `stop_o` is set, `cause_o` holds and later events are ignored. Writing register 5 with bit 0 set clears `stop_o` and `cause_o` to 0, and an event in that same cycle is dropped.
- R8: When control bit 9 is clear, each `br_valid_i` writes `br_target_i` to the next slot. The write slot wraps after slot 255, the entry count saturates at 256, and no stop is raised.
- R9: When control bit 9 is set, captures stop once 256 entries are held. The cycle after the count reaches 256, a stop with cause 6 is raised.
- R10: No trace entry is written while `stop_o` is high.
- R11: Register addresses with bit 8 set read trace slot `reg_addr_i[7:0]`. Register 5 reads as cause in bits [2:0], stop in bit 3 and entry count in bits [16:8]. Writing register 5 with bit 1 set empties the trace buffer.
- R12: After reset, `stop_o` is 0, `cause_o` is 0 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | 32 | Fetch address |
| mem_valid_i | input | 1 | Load/store valid |
| mem_store_i | input | 1 | 1 = store, 0 = load |
| mem_addr_i | input | 32 | Load/store address |
| swbrk_i | input | 1 | Software breakpoint pulse |
| ext_dbg_i | input | 1 | External debug request |
| exc_taken_i | input | 1 | Exception taken |
| exc_vec_i | input | 3 | Exception vector index |
| br_valid_i | input | 1 | Branch target valid for trace |
| br_target_i | input | 32 | Branch target address |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register/trace index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| stop_o | output | 1 | Debug-stop request |
| cause_o | output | 3 | Latched stop cause |

## Verification
A wrong match or a wrong priority shows up on `stop_o` and `cause_o` exactly one edge after the triggering input. The reference model is compared on every clock, so such an error is seen in that cycle. A wrong trace pointer or a wrong count can stay hidden until a read of the status register or of a trace slot. The bench therefore reads these after wrap, after fill and after the freeze, choosing the slot indices around the wrap point. A wrong full-detection path appears as a missing or early cause 6 in the cycle after the 256th capture.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_IBRK  = 3'd1,
    CAUSE_DBRK  = 3'd2,
    CAUSE_SWBRK = 3'd3,
    CAUSE_EXT   = 3'd4,
    CAUSE_VEC   = 3'd5,
    CAUSE_TFULL = 3'd6
  } cause_e;

  localparam int NUM_EV  = 6;
  localparam int NUM_VEC = 8;

  localparam logic [2:0] REG_IB0  = 3'd0;
  localparam logic [2:0] REG_IB1  = 3'd1;
  localparam logic [2:0] REG_DB0  = 3'd2;
  localparam logic [2:0] REG_DB1  = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  typedef struct packed {
    logic [NUM_VEC-1:0] vec_en;    // [17:10]
    logic               fill_once; // [9]
    logic               mask_mode; // [8]
    logic [1:0]         db1_mode;  // [7:6]
    logic [1:0]         db0_mode;  // [5:4]
    logic [1:0]         db_en;     // [3:2]
    logic [1:0]         ib_en;     // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int ADDR_W = 32,
  parameter int NUM_IB = 2
) (
  input  logic [NUM_IB-1:0][ADDR_W-1:0] ib_addr_i,
  input  logic [NUM_IB-1:0]             ib_en_i,
  input  logic                          fetch_valid_i,
  input  logic [ADDR_W-1:0]             fetch_addr_i,
  input  logic [1:0][ADDR_W-1:0]        db_addr_i,
  input  logic [1:0]                    db_en_i,
  input  logic [1:0][1:0]               db_mode_i,
  input  logic                          mask_mode_i,
  input  logic                          mem_valid_i,
  input  logic                          mem_store_i,
  input  logic [ADDR_W-1:0]             mem_addr_i,
  output logic                          ib_hit_o,
  output logic                          db_hit_o
);
  logic [NUM_IB-1:0] ib_match;
  logic [1:0]        acc_sel;
  logic [1:0]        db_match;
  logic [ADDR_W-1:0] cmp_mask;

  for (genvar g = 0; g < NUM_IB; g++) begin : g_ib
    assign ib_match[g] = ib_en_i[g] && fetch_valid_i && (fetch_addr_i == ib_addr_i[g]);
  end

  for (genvar k = 0; k < 2; k++) begin : g_acc
    assign acc_sel[k] = mem_store_i ? db_mode_i[k][1] : db_mode_i[k][0];
  end

  // In mask mode the second register supplies don't-care bits
  assign cmp_mask = mask_mode_i ? ~db_addr_i[1] : '1;

  assign db_match[0] = mem_valid_i && db_en_i[0] && acc_sel[0] &&
                       (((mem_addr_i ^ db_addr_i[0]) & cmp_mask) == '0);
  assign db_match[1] = mem_valid_i && db_en_i[1] && acc_sel[1] && !mask_mode_i &&
                       (mem_addr_i == db_addr_i[1]);

  assign ib_hit_o = |ib_match;
  assign db_hit_o = |db_match;
endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             fill_once_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;
  logic             do_wr;

  assign at_max = (cnt_q == CNT_MAX);
  assign do_wr  = push_i && !flush_i && !(fill_once_i && at_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (do_wr) begin
      wptr_q <= (wptr_q == PTR_MAX) ? '0 : wptr_q + 1'b1;
      if (!at_max) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign full_o    = fill_once_i && at_max;
endmodule

// File: rtl/dbg_stop_latch.sv
module dbg_stop_latch
  import dbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              clear_i,
  output logic              stop_o,
  output cause_e            cause_o
);
  cause_e enc;

  // lowest index (smallest cause code) wins
  always_comb begin
    enc = CAUSE_NONE;
    for (int k = NUM_EV - 1; k >= 0; k--) begin
      if (ev_i[k]) enc = cause_e'(3'(k + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o  <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else if (clear_i) begin
      stop_o  <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else if (!stop_o && (|ev_i)) begin
      stop_o  <= 1'b1;
      cause_o <= enc;
    end
  end
endmodule

// File: rtl/dbg_event_unit.sv
module dbg_event_unit
  import dbg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TRACE_DEPTH = 256,
  localparam int PTR_W  = $clog2(TRACE_DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              mem_valid_i,
  input  logic              mem_store_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              swbrk_i,
  input  logic              ext_dbg_i,
  input  logic              exc_taken_i,
  input  logic [VEC_W-1:0]  exc_vec_i,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              reg_we_i,
  input  logic [PTR_W:0]    reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              stop_o,
  output logic [2:0]        cause_o
);
  localparam int NUM_IB = 2;

  logic [NUM_IB-1:0][ADDR_W-1:0] ib_q;
  logic [1:0][ADDR_W-1:0]        db_q;
  ctrl_t                         ctrl_q;

  logic              reg_sel, is_trace;
  logic              clr_stop, clr_trace;
  logic              ib_hit, db_hit, vec_hit, tr_full;
  logic [NUM_EV-1:0] ev;
  logic [ADDR_W-1:0] tr_rdata, stat;
  logic [CNT_W-1:0]  trace_cnt;
  cause_e            cause;

  assign is_trace  = reg_addr_i[PTR_W];
  assign reg_sel   = reg_we_i && !is_trace;
  assign clr_stop  = reg_sel && (reg_addr_i[2:0] == REG_STAT) && reg_wdata_i[0];
  assign clr_trace = reg_sel && (reg_addr_i[2:0] == REG_STAT) && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ib_q   <= '0;
      db_q   <= '0;
      ctrl_q <= '0;
    end else if (reg_sel) begin
      case (reg_addr_i[2:0])
        REG_IB0:  ib_q[0] <= reg_wdata_i;
        REG_IB1:  ib_q[1] <= reg_wdata_i;
        REG_DB0:  db_q[0] <= reg_wdata_i;
        REG_DB1:  db_q[1] <= reg_wdata_i;
        REG_CTRL: ctrl_q  <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  dbg_bp_match #(.ADDR_W(ADDR_W), .NUM_IB(NUM_IB)) u_match (
    .ib_addr_i     (ib_q),
    .ib_en_i       (ctrl_q.ib_en),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .db_addr_i     (db_q),
    .db_en_i       (ctrl_q.db_en),
    .db_mode_i     ({ctrl_q.db1_mode, ctrl_q.db0_mode}),
    .mask_mode_i   (ctrl_q.mask_mode),
    .mem_valid_i   (mem_valid_i),
    .mem_store_i   (mem_store_i),
    .mem_addr_i    (mem_addr_i),
    .ib_hit_o      (ib_hit),
    .db_hit_o      (db_hit)
  );

  dbg_trace_buf #(.DW(ADDR_W), .DEPTH(TRACE_DEPTH)) u_trace (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (br_valid_i && !stop_o),
    .data_i      (br_target_i),
    .fill_once_i (ctrl_q.fill_once),
    .flush_i     (clr_trace),
    .rd_idx_i    (reg_addr_i[PTR_W-1:0]),
    .rd_data_o   (tr_rdata),
    .cnt_o       (trace_cnt),
    .full_o      (tr_full)
  );

  assign vec_hit = exc_taken_i && ctrl_q.vec_en[exc_vec_i];
  assign ev      = {tr_full, vec_hit, ext_dbg_i, swbrk_i, db_hit, ib_hit};

  dbg_stop_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .clear_i (clr_stop),
    .stop_o  (stop_o),
    .cause_o (cause)
  );
  assign cause_o = cause;

  always_comb begin
    stat            = '0;
    stat[2:0]       = cause;
    stat[3]         = stop_o;
    stat[8 +: CNT_W] = trace_cnt;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_trace) reg_rdata_o = tr_rdata;
    else begin
      case (reg_addr_i[2:0])
        REG_IB0:  reg_rdata_o = ib_q[0];
        REG_IB1:  reg_rdata_o = ib_q[1];
        REG_DB0:  reg_rdata_o = db_q[0];
        REG_DB1:  reg_rdata_o = db_q[1];
        REG_CTRL: reg_rdata_o = ADDR_W'(ctrl_q);
        REG_STAT: reg_rdata_o = stat;
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_event_unit_chk.sv
module dbg_event_unit_chk #(
  parameter int CNT_W = 9,
  parameter int DEPTH = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic [2:0]       cause_i,
  input logic             clear_i,
  input logic             flush_i,
  input logic             swbrk_i,
  input logic             ext_i,
  input logic [CNT_W-1:0] trace_cnt_i
);
  AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !clear_i |=> stop_i && $stable(cause_i)); // R7
  AST_CAUSE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (cause_i != 3'd0) && (cause_i != 3'd7)); // R7
  AST_IDLE_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |-> cause_i == 3'd0); // R12
  AST_SWBRK_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i && !clear_i && swbrk_i |=> stop_i); // R4
  AST_EXT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i && !clear_i && ext_i |=> stop_i); // R4
  AST_TRACE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !flush_i |=> $stable(trace_cnt_i)); // R10
  AST_TRACE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_cnt_i <= CNT_W'(DEPTH)); // R8
endmodule

bind dbg_event_unit dbg_event_unit_chk #(.CNT_W(CNT_W), .DEPTH(TRACE_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_o),
  .cause_i     (cause_o),
  .clear_i     (clr_stop),
  .flush_i     (clr_trace),
  .swbrk_i     (swbrk_i),
  .ext_i       (ext_dbg_i),
  .trace_cnt_i (trace_cnt)
);

// File: tb/dbg_event_unit_tb.sv
module dbg_event_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0, mem_valid = 0, mem_store = 0;
  logic [31:0] fetch_addr = 0, mem_addr = 0, br_tgt = 0, reg_wdata = 0;
  logic        swbrk = 0, ext = 0, exc_taken = 0, br_valid = 0, reg_we = 0;
  logic [2:0]  exc_vec = 0;
  logic [8:0]  reg_addr = 0;
  logic [31:0] rdata;
  logic        stop;
  logic [2:0]  cause;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [31:0] m_ib0 = 0, m_ib1 = 0, m_db0 = 0, m_db1 = 0, m_ctrl = 0;
  logic        m_stop = 0;
  logic [2:0]  m_cause = 0;
  logic [31:0] m_tr [256];
  int          m_wp = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .mem_valid_i(mem_valid), .mem_store_i(mem_store), .mem_addr_i(mem_addr),
    .swbrk_i(swbrk), .ext_dbg_i(ext), .exc_taken_i(exc_taken), .exc_vec_i(exc_vec),
    .br_valid_i(br_valid), .br_target_i(br_tgt),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .stop_o(stop), .cause_o(cause)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [8:0] a);
    logic [31:0] s;
    if (a[8]) return m_tr[a[7:0]];
    s = {15'd0, 9'(m_cnt), 4'd0, m_stop, m_cause};
    case (a[2:0])
      3'd0: return m_ib0;
      3'd1: return m_ib1;
      3'd2: return m_db0;
      3'd3: return m_db1;
      3'd4: return m_ctrl;
      3'd5: return s;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit dmatch(int k, logic [31:0] ba);
    logic [1:0] md;
    logic [31:0] msk;
    md  = (k == 0) ? m_ctrl[5:4] : m_ctrl[7:6];
    msk = (k == 0 && m_ctrl[8]) ? m_db1 : 32'd0;
    if (!mem_valid || !m_ctrl[2+k]) return 0;
    if (!(mem_store ? md[1] : md[0])) return 0;
    if (k == 1 && m_ctrl[8]) return 0;
    return ((mem_addr | msk) == (ba | msk));
  endfunction

  // one clock: predict, step, compare stop/cause
  task automatic cyc();
    int ev;
    bit clr_s, clr_t, fill;
    ev = 0;
    fill = m_ctrl[9];
    if (fill && m_cnt == 256) ev = 6;
    if (exc_taken && m_ctrl[10 + exc_vec]) ev = 5;
    if (ext) ev = 4;
    if (swbrk) ev = 3;
    if (dmatch(0, m_db0) || dmatch(1, m_db1)) ev = 2;
    if (fetch_valid && ((m_ctrl[0] && fetch_addr == m_ib0) || (m_ctrl[1] && fetch_addr == m_ib1))) ev = 1;
    clr_s = reg_we && !reg_addr[8] && reg_addr[2:0] == 3'd5 && reg_wdata[0];
    clr_t = reg_we && !reg_addr[8] && reg_addr[2:0] == 3'd5 && reg_wdata[1];
    @(posedge clk);
    if (clr_t) begin m_wp = 0; m_cnt = 0; end
    else if (br_valid && !m_stop && !(fill && m_cnt == 256)) begin
      m_tr[m_wp] = br_tgt;
      m_wp = (m_wp + 1) % 256;
      if (m_cnt < 256) m_cnt++;
    end
    if (clr_s) begin m_stop = 0; m_cause = 0; end
    else if (!m_stop && ev != 0) begin m_stop = 1; m_cause = 3'(ev); end
    if (reg_we && !reg_addr[8]) begin
      case (reg_addr[2:0])
        3'd0: m_ib0 = reg_wdata;
        3'd1: m_ib1 = reg_wdata;
        3'd2: m_db0 = reg_wdata;
        3'd3: m_db1 = reg_wdata;
        3'd4: m_ctrl = reg_wdata & 32'h3FFFF;
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R7 stop", {31'd0, stop}, {31'd0, m_stop});
    chk("R7 cause", {29'd0, cause}, {29'd0, m_cause});
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd(string req, logic [8:0] a);
    reg_addr = a;
    #1;
    chk(req, rdata, mread(a));
    reg_addr = 0;
  endtask

  task automatic fetch(logic [31:0] a);
    fetch_valid = 1; fetch_addr = a; cyc(); fetch_valid = 0;
  endtask

  task automatic mem(bit st, logic [31:0] a);
    mem_valid = 1; mem_store = st; mem_addr = a; cyc(); mem_valid = 0; mem_store = 0;
  endtask

  task automatic branch(logic [31:0] t);
    br_valid = 1; br_tgt = t; cyc(); br_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 stop", {31'd0, stop}, 0);
    chk("R12 cause", {29'd0, cause}, 0);
    for (int a = 0; a < 6; a++) rd("R12 reg", 9'(a));

    // R1 instruction breakpoint
    wr(0, 32'h1000); wr(4, 32'h1);
    fetch(32'h1004);
    chk("R1 miss", {31'd0, stop}, 0);
    fetch(32'h1000);
    chk("R1 hit", {29'd0, cause}, 1);
    // R7 held, R10 frozen
    swbrk = 1; cyc(); swbrk = 0;
    chk("R7 held", {29'd0, cause}, 1);
    branch(32'hDEAD);
    rd("R10 frozen count", 9'd5);
    wr(5, 32'h1);
    chk("R7 clear", {31'd0, stop}, 0);
    wr(1, 32'h2000);
    fetch(32'h2000);
    chk("R1 disabled", {31'd0, stop}, 0);

    // R2 data breakpoint, loads only
    wr(2, 32'h4000); wr(4, 32'h15);
    mem(1, 32'h4000);
    chk("R2 store ignored", {31'd0, stop}, 0);
    mem(0, 32'h4000);
    chk("R2 load hit", {29'd0, cause}, 2);
    wr(5, 32'h1);

    // R3 mask mode
    wr(3, 32'hFF); wr(4, 32'h1DD);
    mem(0, 32'h40AB);
    chk("R3 masked hit", {29'd0, cause}, 2);
    wr(5, 32'h1);
    mem(0, 32'h41AB);
    chk("R3 unmasked miss", {31'd0, stop}, 0);
    mem(1, 32'h00FF);
    chk("R3 db1 not comparator", {31'd0, stop}, 0);

    // R4
    swbrk = 1; cyc(); swbrk = 0;
    chk("R4 swbrk", {29'd0, cause}, 3);
    wr(5, 32'h1);
    ext = 1; cyc(); ext = 0;
    chk("R4 ext", {29'd0, cause}, 4);
    wr(5, 32'h1);

    // R5 vector trap
    wr(4, 32'h1DD | (32'h1 << 15));
    exc_taken = 1; exc_vec = 2; cyc();
    chk("R5 vec off", {31'd0, stop}, 0);
    exc_vec = 5; cyc(); exc_taken = 0;
    chk("R5 vec on", {29'd0, cause}, 5);
    wr(5, 32'h1);

    // R6 priority
    ext = 1; swbrk = 1; fetch(32'h1000); ext = 0; swbrk = 0;
    chk("R6 ib wins", {29'd0, cause}, 1);
    wr(5, 32'h1);
    ext = 1; exc_taken = 1; mem(0, 32'h4000); ext = 0; exc_taken = 0;
    chk("R6 db wins", {29'd0, cause}, 2);
    // R7 clear drops same-cycle event
    ext = 1; wr(5, 32'h1);
    chk("R7 clear wins", {31'd0, stop}, 0);
    ext = 0;

    // R8 circular trace
    for (int i = 0; i < 300; i++) branch(32'hA000_0000 + 32'(i));
    chk("R8 no stop", {31'd0, stop}, 0);
    rd("R8 count", 9'd5);
    rd("R8 slot0", 9'h100);
    rd("R8 slot43", 9'h12B);
    rd("R8 slot44", 9'h12C);
    rd("R8 slot255", 9'h1FF);
    wr(5, 32'h2);
    rd("R11 flush", 9'd5);

    // R9 fill once
    wr(4, 32'h1DD | (32'h1 << 9));
    for (int i = 0; i < 256; i++) branch(32'hB000_0000 + 32'(i));
    cyc();
    chk("R9 full stop", {29'd0, cause}, 6);
    branch(32'hC0DE);
    rd("R9 count", 9'd5);
    rd("R11 slot255", 9'h1FF);
    rd("R11 slot0", 9'h100);
    rd("R11 ctrl", 9'd4);
    wr(5, 32'h3);
    rd("R11 cleared", 9'd5);
    chk("R9 clear", {31'd0, stop}, 0);
    repeat (3) cyc();
    finish_run();
  end
endmodule